// File: doc/BRIEF.md
# Buffered-Duty PWM Timer

This block is an up-counting pulse-width modulator driven by a count-clock enable strobe. A period compare value fixes the cycle length. Each time the counter reaches it, the counter returns to zero, the output turns active and a one-clock interrupt pulse is raised. A duty compare value marks the count at which the output turns inactive again within the cycle.

The duty value can be rewritten while the timer runs without causing a glitch. A write made while the timer is enabled lands in a holding latch. It reaches the active duty compare only when the counter meets the duty value that was in force before the write. That match must also fall on at least the third count tick after the write. A polarity select flips both the active and the inactive levels. Dropping the enable forces both outputs to their idle values in the same cycle and rewinds the counter.

Top module: `pwm_buffered_timer`

## Requirements
- R1: After the enable goes from 0 to 1, the first count tick is swallowed. With period value P, the first interrupt pulse appears on count tick P+2 after enabling.
- R2: From enabling until the first period match, the output stays at its inactive level.
- R3: On a count tick with the counter equal to the period value, the counter goes to 0, the output goes active and the interrupt output is high for exactly one clock. A full cycle is P+1 count ticks.
- R4: On a count tick with the counter equal to the active duty value D, the output goes inactive and no interrupt is raised. The output is therefore active for D+1 ticks per cycle when D<P, and for the whole cycle when D>=P (a period match takes priority).
- R5: A duty write (write select = 1) made while enabled does not change the running duty. The held value replaces it at a count tick on which the counter equals the old duty value.
- R6: That replacement happens only if the matching tick is at least the third count tick after the write. A blocked value stays held and is applied at the next old-duty match that qualifies.
- R7: With the enable at 0, the interrupt output is 0 and the output sits at its inactive level in the same cycle. The counter and the tick mask are reset, so re-enabling restarts per R1.
- R8: With polarity select 0, the active level is 1 and the inactive level is 0. With polarity select 1, the levels are swapped. After reset, the output is at the inactive level.
- R9: While disabled, a duty write loads the running duty at once, and any held value is moved into the running duty. A period write (write select = 0) always loads at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cnt_tick | input | 1 | Count-clock enable strobe, one clock wide |
| tmr_en | input | 1 | Timer run enable |
| wr_en | input | 1 | Compare register write strobe |
| wr_sel | input | 1 | Write target: 0 period, 1 duty |
| wr_data | input | CNT_W | Write data |
| lvl_inv | input | 1 | Output polarity select |
| pwm_out | output | 1 | PWM output |
| irq_pulse | output | 1 | Period-match interrupt pulse |

## Verification
The bench uses the default build: an 8-bit counter and a three-tick settle window. Short periods are enough to walk complete cycles quickly, including the duty-zero case, the duty-equals-period case and the duty-above-period case. With the window at three, one duty write can be placed exactly on the third tick before the old match and another on the second tick. This exercises both sides of the settle boundary and shows whether a blocked value carries over into the following cycle.

// File: rtl/pwmt_pkg.sv
// Shared types for the buffered-duty PWM timer.
package pwmt_pkg;
    // Target of a compare-register write.
    typedef enum logic {
        SEL_PERIOD = 1'b0,
        SEL_DUTY   = 1'b1
    } cmp_sel_e;
endpackage

// File: rtl/pwmt_counter.sv
// Up-counter with a swallowed first tick after enable.
// Produces period and duty match strobes, qualified by the count tick.
// Assumes tick is one clock wide; a disabled timer holds the counter at 0.
module pwmt_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             en,
    input  logic [CNT_W-1:0] period,
    input  logic [CNT_W-1:0] duty,
    output logic [CNT_W-1:0] cnt,
    output logic             per_hit,
    output logic             duty_hit
);
    logic armed_q;
    logic live_tick;

    // A tick counts only once the first post-enable tick has been swallowed.
    assign live_tick = tick && en && armed_q;
    assign per_hit   = live_tick && (cnt == period);
    assign duty_hit  = live_tick && (cnt == duty);

    // Counter and mask state: rewind when disabled, clear on period match.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cnt     <= '0;
            armed_q <= 1'b0;
        end else if (tick) begin
            if (!armed_q) begin
                armed_q <= 1'b1;
            end else if (per_hit) begin
                cnt <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/pwmt_duty_buf.sv
// Duty compare with a holding latch.
// While running, writes are held and moved to the active duty on an
// old-duty match that is at least SETTLE_TICKS count ticks after the write.
// While disabled, writes load directly and any held value is promoted.
module pwmt_duty_buf #(
    parameter int CNT_W        = 8,
    parameter int SETTLE_TICKS = 3,
    parameter logic [CNT_W-1:0] DUTY_RST = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             tick,
    input  logic             wr_duty,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             duty_hit,
    output logic [CNT_W-1:0] duty_act
);
    localparam int SW = $clog2(SETTLE_TICKS + 1);
    localparam logic [SW-1:0] SETTLE_MAX  = SW'(SETTLE_TICKS);
    localparam logic [SW-1:0] SETTLE_LAST = SW'(SETTLE_TICKS - 1);

    logic             pend_q;
    logic [CNT_W-1:0] pend_val_q;
    logic [SW-1:0]    settle_q;
    logic             settled;

    // The current tick is the SETTLE_TICKS-th or later since the write.
    assign settled = (settle_q >= SETTLE_LAST);

    // Holding latch, settle counter and transfer into the active duty.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            duty_act   <= DUTY_RST;
            pend_q     <= 1'b0;
            pend_val_q <= '0;
            settle_q   <= '0;
        end else if (wr_duty) begin
            if (!en) begin
                duty_act <= wr_data;
                pend_q   <= 1'b0;
            end else begin
                pend_q     <= 1'b1;
                pend_val_q <= wr_data;
                settle_q   <= '0;
            end
        end else if (!en) begin
            if (pend_q) begin
                duty_act <= pend_val_q;
                pend_q   <= 1'b0;
            end
        end else if (pend_q && tick) begin
            if (duty_hit && settled) begin
                duty_act <= pend_val_q;
                pend_q   <= 1'b0;
            end else if (settle_q < SETTLE_MAX) begin
                settle_q <= settle_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/pwmt_out_stage.sv
// Output level register and interrupt pulse.
// A period match wins over a duty match. Both outputs are gated by the
// enable without a register, so disabling takes effect in the same cycle.
module pwmt_out_stage (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic lvl_inv,
    input  logic per_hit,
    input  logic duty_hit,
    output logic pwm_out,
    output logic irq_out
);
    logic act_q;
    logic irq_q;

    // Active flag and one-clock interrupt, both cleared while disabled.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            act_q <= 1'b0;
            irq_q <= 1'b0;
        end else begin
            irq_q <= per_hit;
            if (per_hit) begin
                act_q <= 1'b1;
            end else if (duty_hit) begin
                act_q <= 1'b0;
            end
        end
    end

    // Apply enable gating and the polarity select.
    assign pwm_out = (act_q && en) ^ lvl_inv;
    assign irq_out = irq_q && en;
endmodule

// File: rtl/pwm_buffered_timer.sv
// Top level of the buffered-duty PWM timer.
// Period register loads directly; duty goes through the holding latch.
// Assumes cnt_tick is a single-clock strobe from an external prescaler.
module pwm_buffered_timer #(
    parameter int CNT_W        = 8,
    parameter int SETTLE_TICKS = 3,
    parameter logic [CNT_W-1:0] PERIOD_RST = '1,
    parameter logic [CNT_W-1:0] DUTY_RST   = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_tick,
    input  logic             tmr_en,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             lvl_inv,
    output logic             pwm_out,
    output logic             irq_pulse
);
    import pwmt_pkg::*;

    cmp_sel_e         sel;
    logic [CNT_W-1:0] period_q;
    logic [CNT_W-1:0] duty_act;
    logic [CNT_W-1:0] cnt_q;
    logic             per_hit;
    logic             duty_hit;
    logic             wr_duty;

    assign sel     = cmp_sel_e'(wr_sel);
    assign wr_duty = wr_en && (sel == SEL_DUTY);

    // Period compare register: loads on every period write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            period_q <= PERIOD_RST;
        end else if (wr_en && (sel == SEL_PERIOD)) begin
            period_q <= wr_data;
        end
    end

    pwmt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (cnt_tick),
        .en       (tmr_en),
        .period   (period_q),
        .duty     (duty_act),
        .cnt      (cnt_q),
        .per_hit  (per_hit),
        .duty_hit (duty_hit)
    );

    pwmt_duty_buf #(
        .CNT_W        (CNT_W),
        .SETTLE_TICKS (SETTLE_TICKS),
        .DUTY_RST     (DUTY_RST)
    ) u_duty (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (tmr_en),
        .tick     (cnt_tick),
        .wr_duty  (wr_duty),
        .wr_data  (wr_data),
        .duty_hit (duty_hit),
        .duty_act (duty_act)
    );

    pwmt_out_stage u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (tmr_en),
        .lvl_inv  (lvl_inv),
        .per_hit  (per_hit),
        .duty_hit (duty_hit),
        .pwm_out  (pwm_out),
        .irq_out  (irq_pulse)
    );
endmodule

// File: rtl/pwmt_checker.sv
// Temporal checks for the buffered-duty PWM timer, bound to the top.
module pwmt_checker #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tmr_en,
    input logic             cnt_tick,
    input logic             lvl_inv,
    input logic             pwm_out,
    input logic             irq_pulse,
    input logic [CNT_W-1:0] cnt_q,
    input logic [CNT_W-1:0] duty_act
);
    // R3: the interrupt lasts a single clock.
    p_irq_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |=> !irq_pulse);

    // R3: an interrupt follows only a clock that carried a count tick.
    p_irq_after_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |-> $past(cnt_tick));

    // R7 / R8: disabled means idle interrupt and inactive output level.
    p_idle_when_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !tmr_en |-> (!irq_pulse && (pwm_out == lvl_inv)));

    // R3 / R4: while running, the output turns active only with the interrupt.
    p_active_with_irq_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_en && $past(tmr_en) && $stable(lvl_inv) && $rose(pwm_out ^ lvl_inv))
            |-> irq_pulse);

    // R5: while running, the active duty changes only on a tick at its own match.
    p_duty_swap_at_match_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(duty_act) && $past(tmr_en))
            |-> ($past(cnt_tick) && ($past(cnt_q) == $past(duty_act))));
endmodule

bind pwm_buffered_timer pwmt_checker #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tmr_en    (tmr_en),
    .cnt_tick  (cnt_tick),
    .lvl_inv   (lvl_inv),
    .pwm_out   (pwm_out),
    .irq_pulse (irq_pulse),
    .cnt_q     (cnt_q),
    .duty_act  (duty_act)
);

// File: tb/pwm_buffered_timer_bench.sv
`timescale 1ns/1ps
module pwm_buffered_timer_bench;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cnt_tick = 1'b0;
    logic         tmr_en = 1'b0;
    logic         wr_en = 1'b0;
    logic         wr_sel = 1'b0;
    logic [W-1:0] wr_data = '0;
    logic         lvl_inv = 1'b0;
    logic         pwm_out;
    logic         irq_pulse;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Vector fields: {period, duty, polarity, expected active ticks, expected first-irq tick}
    localparam logic [39:0] VEC [6] = '{
        {8'd5,  8'd2, 8'd0, 8'd3, 8'd7},
        {8'd7,  8'd0, 8'd0, 8'd1, 8'd9},
        {8'd4,  8'd4, 8'd0, 8'd5, 8'd6},
        {8'd3,  8'd9, 8'd1, 8'd4, 8'd5},
        {8'd10, 8'd6, 8'd1, 8'd7, 8'd12},
        {8'd1,  8'd0, 8'd0, 8'd1, 8'd3}
    };

    always #2 clk = ~clk;

    pwm_buffered_timer u_pwm_buffered_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .cnt_tick  (cnt_tick),
        .tmr_en    (tmr_en),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_data   (wr_data),
        .lvl_inv   (lvl_inv),
        .pwm_out   (pwm_out),
        .irq_pulse (irq_pulse)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp_v);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
        end
    endtask

    function automatic bit is_active();
        return pwm_out != lvl_inv;
    endfunction

    task automatic do_tick();
        @(negedge clk) cnt_tick = 1'b1;
        @(negedge clk) cnt_tick = 1'b0;
    endtask

    task automatic do_write(input bit sel, input int val);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = W'(val);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Tick until the interrupt is seen; report the tick count and whether the output stayed idle.
    task automatic wait_irq(output int n, output bit idle_ok);
        n = 0; idle_ok = 1'b1;
        for (int i = 0; i < 300; i++) begin
            do_tick();
            n++;
            if (irq_pulse) break;
            if (is_active()) idle_ok = 1'b0;
        end
    endtask

    // Walk one cycle from an interrupt sample; optional duty write before tick index wr_pos.
    task automatic measure(input int p, input int wr_pos, input int wr_val,
                           output int highs, output bit next_irq);
        highs = 0;
        for (int i = 0; i <= p; i++) begin
            if (is_active()) highs++;
            if (i == wr_pos) do_write(1'b1, wr_val);
            if (i < p) do_tick();
        end
        do_tick();
        next_irq = irq_pulse;
    endtask

    task automatic setup(input int p, input int d, input bit inv);
        @(negedge clk) tmr_en = 1'b0;
        lvl_inv = inv;
        do_write(1'b0, p);
        do_write(1'b1, d);
        @(negedge clk) tmr_en = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int n, h;
        bit ok, nx;
        repeat (3) @(negedge clk);
        // R8: reset leaves output inactive and interrupt low.
        chk(pwm_out == 1'b0, "R8 reset level", pwm_out, 0);
        chk(irq_pulse == 1'b0, "R3 reset irq", irq_pulse, 0);
        rst_n = 1'b1;

        // Table walk: R1 R2 R3 R4 R8 R9 across period/duty/polarity combinations.
        for (int v = 0; v < 6; v++) begin
            int p, d, inv, eh, ef;
            {p, d, inv, eh, ef} = {24'd0, VEC[v][39:32], 24'd0, VEC[v][31:24],
                                   24'd0, VEC[v][23:16], 24'd0, VEC[v][15:8],
                                   24'd0, VEC[v][7:0]};
            setup(p, d, inv[0]);
            chk(!is_active(), "R8 idle level after enable", pwm_out, inv);
            wait_irq(n, ok);
            chk(n == ef, "R1 first irq tick", n, ef);
            chk(ok, "R2 inactive before first match", ok, 1);
            @(negedge clk);
            chk(!irq_pulse, "R3 irq one clock", irq_pulse, 0);
            measure(p, -1, 0, h, nx);
            chk(h == eh, "R4 R9 active ticks per cycle", h, eh);
            chk(nx, "R3 cycle length P+1", nx, 1);
        end

        // R5 / R6: write on the third tick before the old match is accepted.
        setup(9, 2, 1'b0);
        wait_irq(n, ok);
        measure(9, 0, 5, h, nx);
        chk(h == 3, "R5 old duty holds in write cycle", h, 3);
        measure(9, -1, 0, h, nx);
        chk(h == 6, "R6 transfer at third tick", h, 6);
        // R6: write two ticks before the old match is blocked, then applied one cycle later.
        measure(9, 4, 2, h, nx);
        chk(h == 6, "R5 old duty holds after late write", h, 6);
        measure(9, -1, 0, h, nx);
        chk(h == 6, "R6 blocked transfer keeps old duty", h, 6);
        measure(9, -1, 0, h, nx);
        chk(h == 3, "R6 held value applied next match", h, 3);

        // R9: a held value is promoted when the timer is disabled.
        measure(9, 8, 7, h, nx);
        @(negedge clk) tmr_en = 1'b0;
        @(negedge clk) tmr_en = 1'b1;
        wait_irq(n, ok);
        measure(9, -1, 0, h, nx);
        chk(h == 8, "R9 held duty promoted on disable", h, 8);

        // R7: disabling during the active phase drops the output at once.
        do_tick();
        chk(is_active(), "R4 active early in cycle", pwm_out, 1);
        @(negedge clk) tmr_en = 1'b0;
        #1;
        chk(pwm_out == 1'b0, "R7 output idle on disable", pwm_out, 0);

        // R7: disabling while the interrupt is high drops it at once; restart re-masks.
        lvl_inv = 1'b1;
        @(negedge clk) tmr_en = 1'b1;
        wait_irq(n, ok);
        chk(n == 11, "R7 restart masks first tick", n, 11);
        chk(pwm_out == 1'b0, "R8 inverted active level", pwm_out, 0);
        tmr_en = 1'b0;
        #1;
        chk(irq_pulse == 1'b0, "R7 irq cleared on disable", irq_pulse, 0);
        chk(pwm_out == 1'b1, "R8 inverted idle level", pwm_out, 1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule